// File: doc/BRIEF.md
# Dual-network sequence filter

The block sits behind two receive MACs, one per redundant network, and decides for every received frame whether it goes up to the application or is thrown away. Each MAC delivers a descriptor per frame (virtual-link index, one-byte sequence number, a valid strobe and a MAC error flag). The filter keeps a small state entry per virtual link, holding the last sequence number it accepted and whether anything has been accepted yet. With that entry it removes the second copy of a frame that has already arrived from the other network, and it rejects frames that arrive out of order.

Two configuration bits per virtual link select the behaviour. One bit says whether the link is sent on both networks. The other says whether duplicate removal is switched on. Sequence checking runs only when both bits are set, and this document calls that the checked mode. In every other mode, every error-free frame goes through. Decisions come out on two lanes, one per network, one cycle after the descriptor. The lane index is the network tag.

Top module: `dual_net_seq_filter`

## Requirements
- R1: After reset both decision lanes are idle (dec_valid = 00), and no virtual link has a stored sequence number, so the first error-free frame of a checked link is accepted whatever its sequence number.
- R2: A descriptor presented in cycle n produces a decision in cycle n+1. Lane 0 carries network A and lane 1 carries network B, and each lane echoes the descriptor's link index and sequence number.
- R3: A frame with its error flag set is dropped in every mode and leaves the link's stored state unchanged.
- R4: In checked mode (redundant bit = 1 and management bit = 1), a nonzero sequence number is accepted when it is one or two steps ahead of the stored number. A step maps x to x+1, except that 255 maps to 1 and 0 maps to 1. An accepted frame becomes the new stored number.
- R5: In checked mode, a frame whose sequence number equals the stored number is a duplicate and is dropped.
- R6: In checked mode, any other nonzero sequence number (behind the stored number, or more than two steps ahead) is dropped as out of order.
- R7: In checked mode, sequence number 0 marks a transmitter reset. It is accepted and stored, unless the stored number is already 0, in which case the frame is a duplicate of the reset frame and is dropped.
- R8: When both networks present a descriptor in the same cycle, A is judged first. B is then judged against the state as A left it.
- R9: For a redundant link with duplicate removal off, and for any non-redundant link, every error-free frame from either network is accepted.
- R10: Frames on a link that is not in checked mode do not change that link's stored state.
- R11: Each virtual link's state is independent of the others, including when A and B carry different links in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Network A descriptor strobe |
| a_vl | input | VL_W | Network A virtual-link index |
| a_seq | input | 8 | Network A sequence number |
| a_err | input | 1 | Network A MAC error flag |
| b_valid | input | 1 | Network B descriptor strobe |
| b_vl | input | VL_W | Network B virtual-link index |
| b_seq | input | 8 | Network B sequence number |
| b_err | input | 1 | Network B MAC error flag |
| cfg_redundant | input | NUM_VL | Per link: sent on both networks |
| cfg_dedup | input | NUM_VL | Per link: duplicate removal enabled |
| dec_valid | output | 2 | Decision strobe per lane (bit 0 = A, bit 1 = B) |
| dec_accept | output | 2 | 1 = pass frame, 0 = drop |
| dec_vl | output | 2 x VL_W | Echoed link index per lane |
| dec_seq | output | 2 x 8 | Echoed sequence number per lane |

## Verification
The assertions assume that every link index is below NUM_VL. They also assume that the configuration bits of a link hold steady while a descriptor for that link is in flight, since the properties read the bits in the same cycle as the descriptor. The bench changes the configuration only between frames and uses indices well inside the table. The duplicate property for a shared cycle also assumes that A's copy reaches the state first. That holds by construction of the port order, and the bench drives identical copies on both lanes in one cycle to exercise it.

// File: rtl/dnf_pkg.sv
package dnf_pkg;

    localparam int SEQ_W = 8;

    typedef logic [SEQ_W-1:0] seq_t;

    typedef struct packed {
        logic seen;
        seq_t last;
    } vl_state_t;

    // successor on the 1..255 ring; a reset value of 0 is followed by 1
    function automatic seq_t seq_step(input seq_t s);
        return (s == 8'hFF) ? 8'h01 : s + 8'h01;
    endfunction

    function automatic logic seq_in_window(input seq_t last, input seq_t s);
        seq_t one;
        seq_t two;
        one = seq_step(last);
        two = seq_step(one);
        return (s == one) || (s == two);
    endfunction

endpackage

// File: rtl/dnf_judge.sv
module dnf_judge
    import dnf_pkg::*;
(
    input  logic      valid,
    input  logic      err,
    input  seq_t      seq,
    input  logic      redundant,
    input  logic      dedup,
    input  vl_state_t st_in,
    output logic      accept,
    output logic      upd,
    output vl_state_t st_out
);

    logic checked;

    always_comb begin
        checked = redundant && dedup;
        accept  = 1'b0;
        upd     = 1'b0;
        if (valid && !err) begin
            if (!checked) begin
                accept = 1'b1;
            end else if (!st_in.seen) begin
                accept = 1'b1;
                upd    = 1'b1;
            end else if (seq == '0) begin
                accept = (st_in.last != '0);
                upd    = accept;
            end else begin
                accept = seq_in_window(st_in.last, seq);
                upd    = accept;
            end
        end
        st_out.seen = 1'b1;
        st_out.last = seq;
    end

endmodule

// File: rtl/dnf_state.sv
module dnf_state
    import dnf_pkg::*;
#(
    parameter int NUM_VL = 128,
    parameter int VL_W   = (NUM_VL > 1) ? $clog2(NUM_VL) : 1,
    parameter int PORTS  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PORTS-1:0][VL_W-1:0] rd_addr,
    output vl_state_t            rd_data [PORTS],
    input  logic [PORTS-1:0]     wr_en,
    input  logic [PORTS-1:0][VL_W-1:0] wr_addr,
    input  vl_state_t            wr_data [PORTS]
);

    typedef struct packed {
        vl_state_t [NUM_VL-1:0] ent;
    } table_t;

    table_t tbl_d;
    table_t tbl_q;

    always_comb begin
        for (int p = 0; p < PORTS; p++) begin
            rd_data[p] = tbl_q.ent[rd_addr[p]];
        end
    end

    // later ports are written last, so they carry the final value of a link
    always_comb begin
        tbl_d = tbl_q;
        for (int p = 0; p < PORTS; p++) begin
            if (wr_en[p]) begin
                tbl_d.ent[wr_addr[p]] = wr_data[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

endmodule

// File: rtl/dnf_decision_reg.sv
module dnf_decision_reg
    import dnf_pkg::*;
#(
    parameter int VL_W  = 7,
    parameter int LANES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LANES-1:0]           in_valid,
    input  logic [LANES-1:0]           in_accept,
    input  logic [LANES-1:0][VL_W-1:0] in_vl,
    input  logic [LANES-1:0][SEQ_W-1:0] in_seq,
    output logic [LANES-1:0]           dec_valid,
    output logic [LANES-1:0]           dec_accept,
    output logic [LANES-1:0][VL_W-1:0] dec_vl,
    output logic [LANES-1:0][SEQ_W-1:0] dec_seq
);

    typedef struct packed {
        logic [LANES-1:0]            valid;
        logic [LANES-1:0]            accept;
        logic [LANES-1:0][VL_W-1:0]  vl;
        logic [LANES-1:0][SEQ_W-1:0] seq;
    } dec_t;

    dec_t dec_d;
    dec_t dec_q;

    always_comb begin
        dec_d.valid  = in_valid;
        dec_d.accept = in_accept & in_valid;
        dec_d.vl     = in_vl;
        dec_d.seq    = in_seq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign dec_valid  = dec_q.valid;
    assign dec_accept = dec_q.accept;
    assign dec_vl     = dec_q.vl;
    assign dec_seq    = dec_q.seq;

endmodule

// File: rtl/dual_net_seq_filter.sv
module dual_net_seq_filter
    import dnf_pkg::*;
#(
    parameter int NUM_VL = 128,
    parameter int VL_W   = (NUM_VL > 1) ? $clog2(NUM_VL) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 a_valid,
    input  logic [VL_W-1:0]      a_vl,
    input  logic [7:0]           a_seq,
    input  logic                 a_err,
    input  logic                 b_valid,
    input  logic [VL_W-1:0]      b_vl,
    input  logic [7:0]           b_seq,
    input  logic                 b_err,
    input  logic [NUM_VL-1:0]    cfg_redundant,
    input  logic [NUM_VL-1:0]    cfg_dedup,
    output logic [1:0]           dec_valid,
    output logic [1:0]           dec_accept,
    output logic [1:0][VL_W-1:0] dec_vl,
    output logic [1:0][7:0]      dec_seq
);

    localparam int LANES = 2;

    logic [LANES-1:0]            ln_valid;
    logic [LANES-1:0]            ln_err;
    logic [LANES-1:0][VL_W-1:0]  ln_vl;
    logic [LANES-1:0][SEQ_W-1:0] ln_seq;
    logic [LANES-1:0]            ln_accept;
    logic [LANES-1:0]            ln_upd;
    vl_state_t                   rd_st   [LANES];
    vl_state_t                   judge_st[LANES];
    vl_state_t                   new_st  [LANES];

    assign ln_valid = {b_valid, a_valid};
    assign ln_err   = {b_err,   a_err};
    assign ln_vl    = {b_vl,    a_vl};
    assign ln_seq   = {b_seq,   a_seq};

    dnf_state #(
        .NUM_VL (NUM_VL),
        .VL_W   (VL_W),
        .PORTS  (LANES)
    ) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (ln_vl),
        .rd_data (rd_st),
        .wr_en   (ln_upd),
        .wr_addr (ln_vl),
        .wr_data (new_st)
    );

    // lane 0 (network A) is judged first; each later lane sees the
    // update of an earlier lane on the same link
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i == 0) begin : g_first
            assign judge_st[i] = rd_st[i];
        end else begin : g_fwd
            assign judge_st[i] = (ln_upd[i-1] && (ln_vl[i-1] == ln_vl[i]))
                               ? new_st[i-1] : rd_st[i];
        end

        dnf_judge u_judge (
            .valid     (ln_valid[i]),
            .err       (ln_err[i]),
            .seq       (ln_seq[i]),
            .redundant (cfg_redundant[ln_vl[i]]),
            .dedup     (cfg_dedup[ln_vl[i]]),
            .st_in     (judge_st[i]),
            .accept    (ln_accept[i]),
            .upd       (ln_upd[i]),
            .st_out    (new_st[i])
        );
    end

    dnf_decision_reg #(
        .VL_W  (VL_W),
        .LANES (LANES)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (ln_valid),
        .in_accept  (ln_accept),
        .in_vl      (ln_vl),
        .in_seq     (ln_seq),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept),
        .dec_vl     (dec_vl),
        .dec_seq    (dec_seq)
    );

    AST_LANE_A_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        a_valid |=> dec_valid[0] && (dec_vl[0] == $past(a_vl)) && (dec_seq[0] == $past(a_seq))); // R2

    AST_LANE_B_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |=> dec_valid[1] && (dec_seq[1] == $past(b_seq))); // R2

    AST_ERR_A_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_err) |=> !dec_accept[0]); // R3

    AST_ERR_B_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && b_err) |=> !dec_accept[1]); // R3

    AST_SAME_SLOT_DUP: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && b_valid && !a_err && !b_err && (a_vl == b_vl) && (a_seq == b_seq)
         && cfg_redundant[a_vl] && cfg_dedup[a_vl])
        |=> !(dec_accept[0] && dec_accept[1])); // R5

    AST_UNCHECKED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && !a_err && !(cfg_redundant[a_vl] && cfg_dedup[a_vl])) |=> dec_accept[0]); // R9

endmodule

// File: tb/dual_net_seq_filter_test.sv
module dual_net_seq_filter_test;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_VL     = 128;
    localparam int VL_W       = $clog2(NUM_VL);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 a_valid = 1'b0, b_valid = 1'b0;
    logic [VL_W-1:0]      a_vl = '0, b_vl = '0;
    logic [7:0]           a_seq = '0, b_seq = '0;
    logic                 a_err = 1'b0, b_err = 1'b0;
    logic [NUM_VL-1:0]    cfg_redundant = '1;
    logic [NUM_VL-1:0]    cfg_dedup = '1;
    logic [1:0]           dec_valid, dec_accept;
    logic [1:0][VL_W-1:0] dec_vl;
    logic [1:0][7:0]      dec_seq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // captured decision of the last step
    logic [1:0]           r_valid, r_acc;
    logic [1:0][VL_W-1:0] r_vl;
    logic [1:0][7:0]      r_seq;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_net_seq_filter #(.NUM_VL(NUM_VL)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_valid(a_valid), .a_vl(a_vl), .a_seq(a_seq), .a_err(a_err),
        .b_valid(b_valid), .b_vl(b_vl), .b_seq(b_seq), .b_err(b_err),
        .cfg_redundant(cfg_redundant), .cfg_dedup(cfg_dedup),
        .dec_valid(dec_valid), .dec_accept(dec_accept),
        .dec_vl(dec_vl), .dec_seq(dec_seq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // present descriptors at a falling edge; the decision is registered at
    // the next rising edge and read at the following falling edge
    task automatic step(input logic av, input int avl, input int aseq, input logic aerr,
                        input logic bv, input int bvl, input int bseq, input logic berr);
        a_valid = av; a_vl = avl[VL_W-1:0]; a_seq = aseq[7:0]; a_err = aerr;
        b_valid = bv; b_vl = bvl[VL_W-1:0]; b_seq = bseq[7:0]; b_err = berr;
        @(negedge clk);
        r_valid = dec_valid; r_acc = dec_accept; r_vl = dec_vl; r_seq = dec_seq;
        a_valid = 1'b0; b_valid = 1'b0; a_err = 1'b0; b_err = 1'b0;
    endtask

    task automatic send_a(input int vl, input int seq, input logic err, input int exp_acc, input string req);
        step(1'b1, vl, seq, err, 1'b0, 0, 0, 1'b0);
        chk(req, $sformatf("A vl%0d seq%0d accept", vl, seq), int'(r_acc[0]), exp_acc);
    endtask

    task automatic send_b(input int vl, input int seq, input logic err, input int exp_acc, input string req);
        step(1'b0, 0, 0, 1'b0, 1'b1, vl, seq, err);
        chk(req, $sformatf("B vl%0d seq%0d accept", vl, seq), int'(r_acc[1]), exp_acc);
    endtask

    task automatic send_ab(input int avl, input int aseq, input int bvl, input int bseq,
                           input int exp_a, input int exp_b, input string req);
        step(1'b1, avl, aseq, 1'b0, 1'b1, bvl, bseq, 1'b0);
        chk(req, $sformatf("pair A vl%0d seq%0d", avl, aseq), int'(r_acc[0]), exp_a);
        chk(req, $sformatf("pair B vl%0d seq%0d", bvl, bseq), int'(r_acc[1]), exp_b);
    endtask

    task automatic t_reset;
        chk("R1", "dec_valid after reset", int'(dec_valid), 0);
        chk("R1", "dec_accept after reset", int'(dec_accept), 0);
    endtask

    task automatic t_sequence;
        send_a(3, 17, 1'b0, 1, "R1");
        send_b(3, 17, 1'b0, 0, "R5");
        send_a(3, 18, 1'b0, 1, "R4");
        chk("R2", "lane A valid", int'(r_valid), 1);
        chk("R2", "lane A vl echo", int'(r_vl[0]), 3);
        chk("R2", "lane A seq echo", int'(r_seq[0]), 18);
        send_a(3, 20, 1'b0, 1, "R4");
        send_a(3, 23, 1'b0, 0, "R6");
        send_a(3, 19, 1'b0, 0, "R6");
        send_b(3, 21, 1'b0, 1, "R4");
        chk("R2", "lane B valid", int'(r_valid), 2);
        chk("R2", "lane B seq echo", int'(r_seq[1]), 21);
    endtask

    task automatic t_wrap;
        send_a(5, 254, 1'b0, 1, "R1");
        send_a(5, 255, 1'b0, 1, "R4");
        send_a(5, 1, 1'b0, 1, "R4");
        send_a(6, 254, 1'b0, 1, "R11");
        send_a(6, 1, 1'b0, 1, "R4");
        send_a(6, 0, 1'b0, 1, "R7");
        send_b(6, 0, 1'b0, 0, "R7");
        send_a(6, 1, 1'b0, 1, "R7");
        send_a(6, 2, 1'b0, 1, "R4");
    endtask

    task automatic t_same_cycle;
        send_ab(7, 40, 7, 40, 1, 0, "R8");
        send_ab(7, 41, 7, 42, 1, 1, "R8");
        send_ab(7, 44, 7, 43, 1, 0, "R8");
        send_ab(11, 30, 12, 30, 1, 1, "R11");
    endtask

    task automatic t_errors;
        send_a(8, 10, 1'b1, 0, "R3");
        send_a(8, 50, 1'b0, 1, "R3");
        send_a(8, 51, 1'b1, 0, "R3");
        send_b(8, 51, 1'b0, 1, "R3");
    endtask

    task automatic t_modes;
        cfg_dedup[9]     = 1'b0;
        cfg_redundant[10] = 1'b0;
        send_ab(9, 5, 9, 5, 1, 1, "R9");
        send_ab(10, 5, 10, 5, 1, 1, "R9");
        send_a(10, 3, 1'b0, 1, "R9");
        send_b(9, 200, 1'b1, 0, "R3");
        cfg_dedup[9]     = 1'b1;
        cfg_redundant[10] = 1'b1;
        send_a(9, 77, 1'b0, 1, "R10");
        send_a(10, 90, 1'b0, 1, "R10");
        send_b(9, 77, 1'b0, 0, "R5");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sequence();
        t_wrap();
        t_same_cycle();
        t_errors();
        t_modes();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule